// File: doc/BRIEF.md
# Embedded Core Reset Sequencer

This block sits beside an embedded processor core and owns the two lines that stop it: a core-reset bit and a debug-halt bit, both kept in a control register. It also keeps a fault-isolation register (FIR) with a mask. The core reports that it has stopped by raising a halt-acknowledge bit in the FIR. An external JTAG configuration word is read so that a start request can be refused while a debugger holds the core.

A command is offered on a valid/ready handshake and taken only while the block is idle. Simple commands flip one control bit. The safe-reset command never puts a running core straight into reset. It first masks the halt-acknowledge fault, halts the core synchronously and waits a programmable time. It then confirms the halt, resets and unhalts the core, clears the acknowledge and puts the original mask back. Every register write of a sequence happens in its own clock cycle. A one-cycle done pulse closes each command. An error flag and a halt-timeout warning report what went wrong.

Top module: `core_rst_seq`

## Requirements
- R1: While rst_n is low at a clock edge, ctrl_o, fir_o and fir_mask_o become all zeros, done_o, err_o and halt_warn_o become 0, and cmd_ready_o becomes 1.
- R2: Opcodes act on the control register at the accepting edge and touch only one bit. Opcode 1 sets bit 0 (core reset). Opcode 2 clears bit 0. Opcode 3 sets bit 10 (debug halt). Opcode 4 clears bit 10. Opcodes 0 and 7 change nothing.
- R3: Opcode 5 (safe reset) performs one write per cycle, starting in the cycle after acceptance. The order is:
  - save the mask and set mask bit 31;
  - set control bit 10;
  - wait TIMEOUT_CYC cycles;
  - clear FIR bit 31;
  - sample FIR bit 31;
  - set control bit 0;
  - clear control bit 10;
  - clear FIR bit 31;
  - restore the saved mask;
  - pulse done.
- R4: On every cycle each FIR bit is set when its fir_set_i bit is 1. A clear step of the sequencer removes bit 31 only, and a set on the same edge wins over the clear.
- R5: If FIR bit 31 is 0 at the sample step of a safe reset, halt_warn_o rises and the sequence still runs to its end.
- R6: Opcode 6 (start) checks jtag_cfg_i bit 6 at acceptance. If that bit is 1, err_o rises, the control register keeps its value and done follows in the next cycle. If it is 0, control bit 10 is cleared in the next cycle and bit 0 in the one after.
- R7: mask_wr_i loads mask_data_i into the FIR mask only in a cycle where the block is idle. A write offered while a command runs is lost.
- R8: done_o is high for exactly one cycle, in the cycle after a command's last write. err_o and halt_warn_o hold their value until the next command is accepted, which clears them.
- R9: cmd_ready_o is high only while idle. A command is taken on an edge where cmd_valid_i and cmd_ready_o are both 1. A valid command offered while the block is busy is neither taken nor acted on.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cmd_valid_i | input | 1 | Command offered |
| cmd_op_i | input | 3 | Command opcode (see R2, R3, R6) |
| cmd_ready_o | output | 1 | Block idle, command can be taken |
| jtag_cfg_i | input | JTAG_W | JTAG configuration word, bit 6 = debugger halt |
| fir_set_i | input | FIR_W | Per-bit fault set requests, bit 31 = halt acknowledge from the core |
| mask_wr_i | input | 1 | Load FIR mask |
| mask_data_i | input | FIR_W | New FIR mask value |
| ctrl_o | output | CTRL_W | Control register, bit 0 = core reset, bit 10 = debug halt |
| fir_o | output | FIR_W | Fault-isolation register |
| fir_mask_o | output | FIR_W | FIR mask |
| done_o | output | 1 | One-cycle command completion pulse |
| err_o | output | 1 | Start refused because of JTAG halt |
| halt_warn_o | output | 1 | Core did not acknowledge the halt in time |

## Verification
Simple opcodes and a refused start change the control register and err_o at the accepting edge. Their done pulse falls in the next cycle. A safe reset takes TIMEOUT_CYC plus nine cycles from acceptance to done, and a granted start takes three. The bench keeps a queue of expected per-cycle actions, filled when a command is accepted and drained one entry per clock. It compares every output at the falling edge, after all registers on the path have settled. A write order fault therefore shows up in the exact cycle where it differs.

// File: rtl/crs_pkg.sv
// Package: shared opcode and sequencer state types for the core reset sequencer.
// Assumes: opcodes are 3 bits wide; the encoding is part of the block's interface.
package crs_pkg;

    typedef enum logic [2:0] {
        OP_NOP       = 3'd0,
        OP_RST_SET   = 3'd1,
        OP_RST_CLR   = 3'd2,
        OP_HALT_SET  = 3'd3,
        OP_HALT_CLR  = 3'd4,
        OP_SAFE      = 3'd5,
        OP_START     = 3'd6,
        OP_RSVD      = 3'd7
    } op_e;

    typedef enum logic [3:0] {
        ST_IDLE,
        ST_MASK,
        ST_HALT,
        ST_WAIT,
        ST_FCLR_A,
        ST_CHECK,
        ST_RESET,
        ST_UNHALT,
        ST_FCLR_B,
        ST_RESTORE,
        ST_GO_UNHALT,
        ST_GO_UNRESET,
        ST_FIN
    } st_e;

endpackage

// File: rtl/crs_fir_bank.sv
// Module: fault-isolation register, its mask and the saved copy of the mask.
// Assumes: set requests win over the sequencer's clear of the acknowledge bit;
// mask loads from outside are honoured only when the sequencer reports idle.
module crs_fir_bank #(
    parameter int FIR_W    = 32,
    parameter int HACK_BIT = 31
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [FIR_W-1:0] set_i,
    input  logic             clr_hack_i,
    input  logic             mask_save_i,
    input  logic             mask_restore_i,
    input  logic             wr_ok_i,
    input  logic             mask_wr_i,
    input  logic [FIR_W-1:0] mask_data_i,
    output logic [FIR_W-1:0] fir_o,
    output logic [FIR_W-1:0] mask_o
);

    logic [FIR_W-1:0] fir_q;
    logic [FIR_W-1:0] mask_q;
    logic [FIR_W-1:0] saved_q;

    // Per-bit FIR cells; only the acknowledge bit can be cleared by the sequencer.
    for (genvar b = 0; b < FIR_W; b++) begin : g_fir
        localparam bit CLEARABLE = (b == HACK_BIT);
        always_ff @(posedge clk) begin
            if (!rst_n)
                fir_q[b] <= 1'b0;
            else
                fir_q[b] <= (fir_q[b] & ~(CLEARABLE & clr_hack_i)) | set_i[b];
        end
    end

    // Mask register: save-and-mask, restore, or external load when idle.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            mask_q  <= '0;
            saved_q <= '0;
        end else if (mask_save_i) begin
            saved_q           <= mask_q;
            mask_q[HACK_BIT]  <= 1'b1;
        end else if (mask_restore_i) begin
            mask_q <= saved_q;
        end else if (wr_ok_i && mask_wr_i) begin
            mask_q <= mask_data_i;
        end
    end

    assign fir_o  = fir_q;
    assign mask_o = mask_q;

    a_r4_set_wins: assert property (@(posedge clk) disable iff (!rst_n)
        set_i[HACK_BIT] |=> fir_q[HACK_BIT]);

    a_r7_busy_wr_ignored: assert property (@(posedge clk) disable iff (!rst_n)
        (!wr_ok_i && !mask_save_i && !mask_restore_i) |=> $stable(mask_q));

endmodule

// File: rtl/crs_timer.sv
// Module: halt wait timer; counts while run is high and flags the last cycle.
// Assumes: TIMEOUT_CYC >= 2; run stays high until expire has been seen.
module crs_timer #(
    parameter int TIMEOUT_CYC = 125000
) (
    input  logic clk,
    input  logic rst_n,
    input  logic run_i,
    output logic expire_o
);

    localparam int CNT_W = (TIMEOUT_CYC > 1) ? $clog2(TIMEOUT_CYC) : 1;
    localparam logic [CNT_W-1:0] LAST = CNT_W'(TIMEOUT_CYC - 1);

    logic [CNT_W-1:0] cnt_q;

    // Counter: advances while running, returns to zero otherwise.
    always_ff @(posedge clk) begin
        if (!rst_n || !run_i)
            cnt_q <= '0;
        else
            cnt_q <= cnt_q + CNT_W'(1);
    end

    assign expire_o = run_i && (cnt_q == LAST);

    a_r3_count_cleared: assert property (@(posedge clk) disable iff (!rst_n)
        !run_i |=> (cnt_q == '0));

endmodule

// File: rtl/crs_seq_fsm.sv
// Module: command sequencer; owns the control register and the status flags.
// Assumes: one register write per state; the FIR and mask live in crs_fir_bank.
module crs_seq_fsm
    import crs_pkg::*;
#(
    parameter int CTRL_W   = 32,
    parameter int RST_BIT  = 0,
    parameter int HALT_BIT = 10
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cmd_valid_i,
    input  logic [2:0]        cmd_op_i,
    output logic              cmd_ready_o,
    input  logic              jtag_halt_i,
    input  logic              hack_i,
    input  logic              tmr_expire_i,
    output logic              tmr_run_o,
    output logic              fir_clr_o,
    output logic              mask_save_o,
    output logic              mask_restore_o,
    output logic              idle_o,
    output logic [CTRL_W-1:0] ctrl_o,
    output logic              done_o,
    output logic              err_o,
    output logic              warn_o
);

    st_e               state_q;
    logic [CTRL_W-1:0] ctrl_q;
    logic              err_q;
    logic              warn_q;
    logic              accept;

    assign accept = cmd_valid_i && (state_q == ST_IDLE);

    // State, control register and flags advance one write per cycle.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
            ctrl_q  <= '0;
            err_q   <= 1'b0;
            warn_q  <= 1'b0;
        end else begin
            case (state_q)
                ST_IDLE: if (cmd_valid_i) begin
                    err_q  <= 1'b0;
                    warn_q <= 1'b0;
                    state_q <= ST_FIN;
                    case (cmd_op_i)
                        OP_RST_SET:  ctrl_q[RST_BIT]  <= 1'b1;
                        OP_RST_CLR:  ctrl_q[RST_BIT]  <= 1'b0;
                        OP_HALT_SET: ctrl_q[HALT_BIT] <= 1'b1;
                        OP_HALT_CLR: ctrl_q[HALT_BIT] <= 1'b0;
                        OP_SAFE:     state_q <= ST_MASK;
                        OP_START: begin
                            if (jtag_halt_i) err_q <= 1'b1;
                            else             state_q <= ST_GO_UNHALT;
                        end
                        default: ;
                    endcase
                end
                ST_MASK:    state_q <= ST_HALT;
                ST_HALT: begin
                    ctrl_q[HALT_BIT] <= 1'b1;
                    state_q <= ST_WAIT;
                end
                ST_WAIT:    if (tmr_expire_i) state_q <= ST_FCLR_A;
                ST_FCLR_A:  state_q <= ST_CHECK;
                ST_CHECK: begin
                    if (!hack_i) warn_q <= 1'b1;
                    state_q <= ST_RESET;
                end
                ST_RESET: begin
                    ctrl_q[RST_BIT] <= 1'b1;
                    state_q <= ST_UNHALT;
                end
                ST_UNHALT: begin
                    ctrl_q[HALT_BIT] <= 1'b0;
                    state_q <= ST_FCLR_B;
                end
                ST_FCLR_B:  state_q <= ST_RESTORE;
                ST_RESTORE: state_q <= ST_FIN;
                ST_GO_UNHALT: begin
                    ctrl_q[HALT_BIT] <= 1'b0;
                    state_q <= ST_GO_UNRESET;
                end
                ST_GO_UNRESET: begin
                    ctrl_q[RST_BIT] <= 1'b0;
                    state_q <= ST_FIN;
                end
                default:    state_q <= ST_IDLE;
            endcase
        end
    end

    // Strobes decoded from the current state for the FIR bank and timer.
    always_comb begin
        cmd_ready_o    = (state_q == ST_IDLE);
        idle_o         = (state_q == ST_IDLE);
        done_o         = (state_q == ST_FIN);
        tmr_run_o      = (state_q == ST_WAIT);
        fir_clr_o      = (state_q == ST_FCLR_A) || (state_q == ST_FCLR_B);
        mask_save_o    = (state_q == ST_MASK);
        mask_restore_o = (state_q == ST_RESTORE);
    end

    assign ctrl_o = ctrl_q;
    assign err_o  = err_q;
    assign warn_o = warn_q;

    a_r2_reset_set: assert property (@(posedge clk) disable iff (!rst_n)
        (accept && cmd_op_i == OP_RST_SET) |=> ctrl_o[RST_BIT]);

    a_r6_jtag_block: assert property (@(posedge clk) disable iff (!rst_n)
        (accept && cmd_op_i == OP_START && jtag_halt_i) |=> ($stable(ctrl_o) && err_o));

    a_r8_done_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |=> !done_o);

    a_r9_ready_after_done: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |=> cmd_ready_o);

endmodule

// File: rtl/core_rst_seq.sv
// Module: top of the core reset sequencer; wires sequencer, timer and FIR bank.
// Assumes: TIMEOUT_CYC is the halt wait in cycles (1 ms at 125 MHz by default).
module core_rst_seq #(
    parameter int CTRL_W      = 32,
    parameter int FIR_W       = 32,
    parameter int JTAG_W      = 32,
    parameter int RST_BIT     = 0,
    parameter int HALT_BIT    = 10,
    parameter int HACK_BIT    = 31,
    parameter int JHALT_BIT   = 6,
    parameter int TIMEOUT_CYC = 125000
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cmd_valid_i,
    input  logic [2:0]        cmd_op_i,
    output logic              cmd_ready_o,
    input  logic [JTAG_W-1:0] jtag_cfg_i,
    input  logic [FIR_W-1:0]  fir_set_i,
    input  logic              mask_wr_i,
    input  logic [FIR_W-1:0]  mask_data_i,
    output logic [CTRL_W-1:0] ctrl_o,
    output logic [FIR_W-1:0]  fir_o,
    output logic [FIR_W-1:0]  fir_mask_o,
    output logic              done_o,
    output logic              err_o,
    output logic              halt_warn_o
);

    logic tmr_run, tmr_expire, fir_clr, mask_save, mask_restore, idle;
    logic unused_jtag;

    assign unused_jtag = ^jtag_cfg_i;

    crs_seq_fsm #(
        .CTRL_W   (CTRL_W),
        .RST_BIT  (RST_BIT),
        .HALT_BIT (HALT_BIT)
    ) u_fsm (
        .clk            (clk),
        .rst_n          (rst_n),
        .cmd_valid_i    (cmd_valid_i),
        .cmd_op_i       (cmd_op_i),
        .cmd_ready_o    (cmd_ready_o),
        .jtag_halt_i    (jtag_cfg_i[JHALT_BIT]),
        .hack_i         (fir_o[HACK_BIT]),
        .tmr_expire_i   (tmr_expire),
        .tmr_run_o      (tmr_run),
        .fir_clr_o      (fir_clr),
        .mask_save_o    (mask_save),
        .mask_restore_o (mask_restore),
        .idle_o         (idle),
        .ctrl_o         (ctrl_o),
        .done_o         (done_o),
        .err_o          (err_o),
        .warn_o         (halt_warn_o)
    );

    crs_timer #(
        .TIMEOUT_CYC (TIMEOUT_CYC)
    ) u_tmr (
        .clk      (clk),
        .rst_n    (rst_n),
        .run_i    (tmr_run),
        .expire_o (tmr_expire)
    );

    crs_fir_bank #(
        .FIR_W    (FIR_W),
        .HACK_BIT (HACK_BIT)
    ) u_fir (
        .clk            (clk),
        .rst_n          (rst_n),
        .set_i          (fir_set_i),
        .clr_hack_i     (fir_clr),
        .mask_save_i    (mask_save),
        .mask_restore_i (mask_restore),
        .wr_ok_i        (idle),
        .mask_wr_i      (mask_wr_i),
        .mask_data_i    (mask_data_i),
        .fir_o          (fir_o),
        .mask_o         (fir_mask_o)
    );

endmodule

// File: tb/sim_core_rst_seq.sv
module sim_core_rst_seq;

    localparam int TMO = 20;

    // Action codes of the reference model's per-cycle script.
    localparam int A_DONE = 0, A_MSAVE = 1, A_HALT1 = 2, A_WAIT = 3, A_FCLR = 4,
                   A_CHECK = 5, A_RST1 = 6, A_HALT0 = 7, A_RST0 = 8, A_REST = 9;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cmd_valid_i = 1'b0;
    logic [2:0]  cmd_op_i = 3'd0;
    logic        cmd_ready_o;
    logic [31:0] jtag_cfg_i = '0;
    logic [31:0] fir_set_i = '0;
    logic        mask_wr_i = 1'b0;
    logic [31:0] mask_data_i = '0;
    logic [31:0] ctrl_o, fir_o, fir_mask_o;
    logic        done_o, err_o, halt_warn_o;

    int checks = 0;
    int errors = 0;
    int cycles = 0;
    bit core_ok = 1'b1;
    logic [31:0] noise = '0;

    // Reference model state.
    int          q[$];
    logic [31:0] m_ctrl = '0, m_fir = '0, m_mask = '0, m_saved = '0;
    logic        m_err = 1'b0, m_warn = 1'b0;

    always #4 clk = ~clk;

    core_rst_seq #(.TIMEOUT_CYC(TMO)) u0 (
        .clk(clk), .rst_n(rst_n), .cmd_valid_i(cmd_valid_i), .cmd_op_i(cmd_op_i),
        .cmd_ready_o(cmd_ready_o), .jtag_cfg_i(jtag_cfg_i), .fir_set_i(fir_set_i),
        .mask_wr_i(mask_wr_i), .mask_data_i(mask_data_i), .ctrl_o(ctrl_o),
        .fir_o(fir_o), .fir_mask_o(fir_mask_o), .done_o(done_o), .err_o(err_o),
        .halt_warn_o(halt_warn_o)
    );

    task automatic chk(input string req, input string what, input logic [31:0] act,
                       input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s %s actual=%h expected=%h at cycle %0d", req, what, act, exp, cycles);
        end
    endtask

    // Behavioural model, advanced on each rising edge from the same inputs.
    always @(posedge clk) begin
        logic [31:0] nf;
        int a;
        cycles++;
        if (!rst_n) begin
            q.delete();
            m_ctrl = '0; m_fir = '0; m_mask = '0; m_saved = '0;
            m_err = 1'b0; m_warn = 1'b0;
        end else begin
            nf = m_fir | fir_set_i;
            if (q.size() > 0) begin
                a = q.pop_front();
                case (a)
                    A_MSAVE: begin m_saved = m_mask; m_mask[31] = 1'b1; end
                    A_HALT1: m_ctrl[10] = 1'b1;
                    A_FCLR:  nf = (m_fir & ~32'h8000_0000) | fir_set_i;
                    A_CHECK: if (!m_fir[31]) m_warn = 1'b1;
                    A_RST1:  m_ctrl[0] = 1'b1;
                    A_HALT0: m_ctrl[10] = 1'b0;
                    A_RST0:  m_ctrl[0] = 1'b0;
                    A_REST:  m_mask = m_saved;
                    default: ;
                endcase
            end else begin
                if (mask_wr_i) m_mask = mask_data_i;
                if (cmd_valid_i) begin
                    m_err = 1'b0; m_warn = 1'b0;
                    case (cmd_op_i)
                        3'd1: m_ctrl[0] = 1'b1;
                        3'd2: m_ctrl[0] = 1'b0;
                        3'd3: m_ctrl[10] = 1'b1;
                        3'd4: m_ctrl[10] = 1'b0;
                        3'd5: begin
                            q.push_back(A_MSAVE); q.push_back(A_HALT1);
                            for (int i = 0; i < TMO; i++) q.push_back(A_WAIT);
                            q.push_back(A_FCLR); q.push_back(A_CHECK);
                            q.push_back(A_RST1); q.push_back(A_HALT0);
                            q.push_back(A_FCLR); q.push_back(A_REST);
                        end
                        3'd6: if (jtag_cfg_i[6]) m_err = 1'b1;
                              else begin q.push_back(A_HALT0); q.push_back(A_RST0); end
                        default: ;
                    endcase
                    q.push_back(A_DONE);
                end
            end
            m_fir = nf;
        end
    end

    // Compare every output against the model on each falling edge.
    always @(negedge clk) begin
        if (rst_n) begin
            chk("R2", "ctrl", ctrl_o, m_ctrl);
            chk("R4", "fir", fir_o, m_fir);
            chk("R7", "mask", fir_mask_o, m_mask);
            chk("R8", "done", {31'd0, done_o}, {31'd0, q.size() > 0 && q[0] == A_DONE});
            chk("R6", "err", {31'd0, err_o}, {31'd0, m_err});
            chk("R5", "warn", {31'd0, halt_warn_o}, {31'd0, m_warn});
            chk("R9", "ready", {31'd0, cmd_ready_o}, {31'd0, q.size() == 0});
        end
    end

    // One cycle step; drives the core's halt acknowledge from the halt line.
    task automatic cyc();
        @(negedge clk);
        fir_set_i = noise | {core_ok & ctrl_o[10], 31'd0};
    endtask

    task automatic do_cmd(input logic [2:0] op);
        while (!cmd_ready_o) cyc();
        cmd_valid_i = 1'b1; cmd_op_i = op;
        cyc();
        cmd_valid_i = 1'b0;
        while (!cmd_ready_o) cyc();
    endtask

    // Watchdog.
    initial begin
        repeat (100000) @(posedge clk);
        errors++;
        $display("FAIL watchdog expired");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (3) cyc();
        rst_n = 1'b1;
        // R1: reset state
        chk("R1", "ctrl", ctrl_o, 32'h0);
        chk("R1", "fir", fir_o, 32'h0);
        chk("R1", "mask", fir_mask_o, 32'h0);
        chk("R1", "flags", {29'd0, done_o, err_o, halt_warn_o}, 32'h0);
        chk("R1", "ready", {31'd0, cmd_ready_o}, 32'h1);

        // R7: load mask while idle
        mask_wr_i = 1'b1; mask_data_i = 32'h0000_00F0; cyc(); mask_wr_i = 1'b0; cyc();
        chk("R7", "mask load", fir_mask_o, 32'h0000_00F0);

        // R2: simple opcodes and no-ops
        do_cmd(3'd1); do_cmd(3'd3);
        chk("R2", "both set", ctrl_o, 32'h0000_0401);
        do_cmd(3'd0); do_cmd(3'd7);
        chk("R2", "nop", ctrl_o, 32'h0000_0401);
        do_cmd(3'd4);
        chk("R2", "halt clr", ctrl_o, 32'h0000_0001);

        // R4: a non-acknowledge fault bit sticks
        noise = 32'h0000_0008; cyc(); noise = '0; cyc();
        chk("R4", "sticky", fir_o & 32'h0000_0008, 32'h0000_0008);

        // R6: start refused by JTAG halt, then granted
        do_cmd(3'd3);
        jtag_cfg_i = 32'h0000_0040;
        do_cmd(3'd6);
        chk("R6", "refused err", {31'd0, err_o}, 32'h1);
        chk("R6", "refused ctrl", ctrl_o, 32'h0000_0401);
        jtag_cfg_i = 32'h0000_0000;
        do_cmd(3'd6);
        chk("R6", "granted", ctrl_o, 32'h0);

        // R3: safe reset with a responsive core; busy command and mask write lost
        core_ok = 1'b1;
        cmd_valid_i = 1'b1; cmd_op_i = 3'd5; cyc();
        cmd_op_i = 3'd2;
        mask_wr_i = 1'b1; mask_data_i = 32'hFFFF_FFFF;
        repeat (4) cyc();
        cmd_valid_i = 1'b0; mask_wr_i = 1'b0;
        while (!cmd_ready_o) cyc();
        chk("R3", "ctrl end", ctrl_o, 32'h0000_0001);
        chk("R3", "mask restored", fir_mask_o, 32'h0000_00F0);
        chk("R5", "no warn", {31'd0, halt_warn_o}, 32'h0);

        // R5: safe reset with a core that never acknowledges
        core_ok = 1'b0;
        do_cmd(3'd5);
        chk("R5", "warn", {31'd0, halt_warn_o}, 32'h1);
        chk("R3", "ctrl end nack", ctrl_o, 32'h0000_0001);
        do_cmd(3'd0);
        chk("R8", "flags cleared", {31'd0, halt_warn_o}, 32'h0);

        repeat (3) cyc();
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule